// File: doc/BRIEF.md
# Dual-Edge Video Lane Deserializer

This block sits behind the line receivers of a column driver's reduced-swing differential video input. It takes twelve single-ended data lanes and the resolved bus clock. Each colour (red, green, blue) uses three of the lanes: a most-, a middle- and a least-significant lane. A 6-bit colour word crosses those three lanes as two half-words. Even-numbered bits travel first and odd-numbered bits follow on the opposite clock edge. The block rebuilds one full pixel per clock period and presents it with a valid flag.

Two straps adapt the block to board routing. The swap strap mirrors the lane order so that adjacent drivers can share a bus with fewer routing corners. Because the differential pairs are also crossed in that case, every lane and the clock arrive complemented. The invert strap complements the video data.

Top module: `rsds_pix_deser`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first complete pixel, `pix_valid_o` is 0 and `red_o`, `grn_o` and `blu_o` are all zero.
- R2: With the swap strap low, lanes 0, 1 and 2 carry the blue most-, middle- and least-significant bits, lanes 3, 4 and 5 the green ones, and lanes 6, 7 and 8 the red ones.
- R3: With the swap strap high, lanes 3, 4 and 5 carry the red least-, middle- and most-significant bits, lanes 6, 7 and 8 the green ones, and lanes 9, 10 and 11 the blue ones. Every data lane is received complemented.
- R4: In each output word, the first half-word's most-, middle- and least-significant lane bits land in bits 4, 2 and 0, and the second half-word's land in bits 5, 3 and 1.
- R5: When `inv_i` is high, every decoded data bit is complemented. Combined with the complement from the swap strap, the two cancel.
- R6: With the swap strap low, `pix_valid_o` first rises on the second rising edge of `clk_i` after reset release. With it high, `pix_valid_o` first rises on the first rising edge that follows a falling edge after release. Once high, it stays high every cycle.
- R7: Unused lanes do not affect the output. These are lanes 9 to 11 with the swap strap low, and lanes 0 to 2 with it high.
- R8: `swap_i` is sampled only while `rst_ni` is low. Changing it afterwards has no effect on decoding.
- R9: With the swap strap low, the first half-word is taken on a rising edge of `clk_i` and the second on the next falling edge. The pixel appears after the following rising edge.
- R10: With the swap strap high, the clock phase is complemented. The first half-word is taken on a falling edge of `clk_i` and the second on the next rising edge, and the pixel appears after that rising edge. In both modes the block delivers one new pixel per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Resolved bus clock; both edges carry data |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_i | input | 12 | Resolved data lanes |
| swap_i | input | 1 | Mirrored lane order and complemented polarity strap |
| inv_i | input | 1 | Data invert strap |
| pix_valid_o | output | 1 | A complete pixel is present on the colour outputs |
| red_o | output | 6 | Red colour word |
| grn_o | output | 6 | Green colour word |
| blu_o | output | 6 | Blue colour word |

## Verification
The assertions assume that the lanes settle between clock edges and that `inv_i` holds steady across both halves of a pixel. They also assume that `swap_i` reaches its final value before the last clock edge of reset. The stimulus changes lanes one time unit after each edge and changes `inv_i` only together with a pixel's first half-word. It holds reset for several clocks with the strap already set. It releases reset just after a rising edge, so the first-valid cycle is fixed in both lane orders.

// File: rtl/rsds_deser_pkg.sv
`timescale 1ns/1ps
package rsds_deser_pkg;
  localparam int unsigned COLOUR_CNT   = 3;   // index 0 blue, 1 green, 2 red
  localparam int unsigned DEF_LANE_CNT = 12;
  localparam int unsigned DEF_HALF_W   = 3;

  typedef enum logic [1:0] {
    COL_BLUE  = 2'd0,
    COL_GREEN = 2'd1,
    COL_RED   = 2'd2
  } colour_e;
endpackage

// File: rtl/rsds_lane_map.sv
`timescale 1ns/1ps
module rsds_lane_map
  import rsds_deser_pkg::*;
#(
  parameter int unsigned LANE_CNT = DEF_LANE_CNT,
  parameter int unsigned HALF_W   = DEF_HALF_W
) (
  input  logic [LANE_CNT-1:0]                   lane_i,
  input  logic                                  swap_i,
  input  logic                                  flip_i,
  output logic [COLOUR_CNT-1:0][HALF_W-1:0]     half_o
);
  for (genvar c = 0; c < COLOUR_CNT; c++) begin : g_col
    for (genvar s = 0; s < HALF_W; s++) begin : g_sig
      // default order puts the msb lane first in each group; swap mirrors it
      localparam int unsigned DefLane = c * HALF_W + (HALF_W - 1 - s);
      localparam int unsigned SwpLane = LANE_CNT - 1 - DefLane;
      assign half_o[c][s] = (swap_i ? lane_i[SwpLane] : lane_i[DefLane]) ^ flip_i;
    end
  end
endmodule

// File: rtl/rsds_edge_capture.sv
`timescale 1ns/1ps
module rsds_edge_capture #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         swap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] half0_o,
  output logic [W-1:0] half1_o,
  output logic         pair_ok_o
);
  logic [W-1:0] rise_q, fall_q;
  logic         rise_seen_q, fall_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q      <= '0;
      rise_seen_q <= 1'b0;
    end else begin
      rise_q      <= d_i;
      rise_seen_q <= 1'b1;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_q      <= '0;
      fall_seen_q <= 1'b0;
    end else begin
      fall_q      <= d_i;
      fall_seen_q <= 1'b1;
    end
  end

  // swapped clock: its rising edge is our falling edge, so the pair closes on
  // the rising edge with the live lanes as second half
  assign half0_o   = swap_i ? fall_q : rise_q;
  assign half1_o   = swap_i ? d_i    : fall_q;
  assign pair_ok_o = swap_i ? fall_seen_q : rise_seen_q;
endmodule

// File: rtl/rsds_word_pack.sv
`timescale 1ns/1ps
module rsds_word_pack
  import rsds_deser_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              pair_ok_i,
  input  logic [COLOUR_CNT-1:0][HALF_W-1:0] half0_i,
  input  logic [COLOUR_CNT-1:0][HALF_W-1:0] half1_i,
  output logic                              valid_o,
  output logic [COLOUR_CNT-1:0][WORD_W-1:0] word_o
);
  logic [COLOUR_CNT-1:0][WORD_W-1:0] word_d;

  for (genvar c = 0; c < COLOUR_CNT; c++) begin : g_col
    for (genvar s = 0; s < HALF_W; s++) begin : g_bit
      assign word_d[c][2*s]   = half0_i[c][s];
      assign word_d[c][2*s+1] = half1_i[c][s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= pair_ok_i;
      if (pair_ok_i) word_o <= word_d;
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (word_o == '0)); // R1
endmodule

// File: rtl/rsds_pix_deser.sv
`timescale 1ns/1ps
module rsds_pix_deser
  import rsds_deser_pkg::*;
#(
  parameter int unsigned LANE_CNT = DEF_LANE_CNT,
  parameter int unsigned HALF_W   = DEF_HALF_W,
  localparam int unsigned WORD_W  = 2 * HALF_W,
  localparam int unsigned HW_BITS = COLOUR_CNT * HALF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANE_CNT-1:0] lane_i,
  input  logic                swap_i,
  input  logic                inv_i,
  output logic                pix_valid_o,
  output logic [WORD_W-1:0]   red_o,
  output logic [WORD_W-1:0]   grn_o,
  output logic [WORD_W-1:0]   blu_o
);
  logic                              swap_q;
  logic [COLOUR_CNT-1:0][HALF_W-1:0] hw, h0, h1;
  logic [COLOUR_CNT-1:0][WORD_W-1:0] word;
  logic [HW_BITS-1:0]                h0_flat, h1_flat;
  logic                              pair_ok;

  // strap: loaded only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) swap_q <= swap_i;
  end

  rsds_lane_map #(.LANE_CNT(LANE_CNT), .HALF_W(HALF_W)) i_map (
    .lane_i (lane_i),
    .swap_i (swap_q),
    .flip_i (swap_q ^ inv_i),
    .half_o (hw)
  );

  rsds_edge_capture #(.W(HW_BITS)) i_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_i    (swap_q),
    .d_i       (hw),
    .half0_o   (h0_flat),
    .half1_o   (h1_flat),
    .pair_ok_o (pair_ok)
  );

  assign h0 = h0_flat;
  assign h1 = h1_flat;

  rsds_word_pack #(.HALF_W(HALF_W)) i_pack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pair_ok_i (pair_ok),
    .half0_i   (h0),
    .half1_i   (h1),
    .valid_o   (pix_valid_o),
    .word_o    (word)
  );

  assign red_o = word[COL_RED];
  assign grn_o = word[COL_GREEN];
  assign blu_o = word[COL_BLUE];

  logic [COLOUR_CNT-1:0][HALF_W-1:0] even_bits, odd_bits;
  for (genvar c = 0; c < COLOUR_CNT; c++) begin : g_chk
    for (genvar s = 0; s < HALF_W; s++) begin : g_bit
      assign even_bits[c][s] = word[c][2*s];
      assign odd_bits[c][s]  = word[c][2*s+1];
    end
  end

  AST_EVEN_FROM_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !swap_q) |-> (even_bits == $past(hw, 2))); // R4
  AST_ODD_FROM_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && swap_q) |-> (odd_bits == $past(hw, 1))); // R10
endmodule

// File: tb/test_rsds_pix_deser.sv
`timescale 1ns/1ps
module test_rsds_pix_deser;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {inv, red, green, blue}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 6'h00, 6'h00, 6'h00},
    {1'b0, 6'h3f, 6'h00, 6'h15},
    {1'b0, 6'h2a, 6'h15, 6'h3f},
    {1'b1, 6'h01, 6'h20, 6'h10},
    {1'b1, 6'h3f, 6'h3f, 6'h3f},
    {1'b0, 6'h12, 6'h34, 6'h0c},
    {1'b1, 6'h2d, 6'h07, 6'h38},
    {1'b0, 6'h33, 6'h0f, 6'h2c}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] lane = '0;
  logic        swap = 1'b0;
  logic        inv = 1'b0;
  logic        valid;
  logic [5:0]  red, grn, blu;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsds_pix_deser i_rsds_pix_deser (
    .clk_i(clk), .rst_ni(rst_n), .lane_i(lane), .swap_i(swap), .inv_i(inv),
    .pix_valid_o(valid), .red_o(red), .grn_o(grn), .blu_o(blu)
  );

  // lane encoding written from R2/R3/R5/R7
  function automatic logic [11:0] enc(input logic [5:0] r, g, b, input int h,
                                      input bit swp, input bit iv, input logic [2:0] junk);
    logic [11:0] l;
    logic [2:0] hr, hg, hb;
    hr = {r[4+h], r[2+h], r[h]};
    hg = {g[4+h], g[2+h], g[h]};
    hb = {b[4+h], b[2+h], b[h]};
    l = '0;
    if (!swp) begin
      l[0] = hb[2]; l[1] = hb[1]; l[2] = hb[0];
      l[3] = hg[2]; l[4] = hg[1]; l[5] = hg[0];
      l[6] = hr[2]; l[7] = hr[1]; l[8] = hr[0];
    end else begin
      l[3] = hr[0]; l[4]  = hr[1]; l[5]  = hr[2];
      l[6] = hg[0]; l[7]  = hg[1]; l[8]  = hg[2];
      l[9] = hb[0]; l[10] = hb[1]; l[11] = hb[2];
    end
    if (swp ^ iv) l = ~l;
    if (!swp) l[11:9] = junk; else l[2:0] = junk;
    return l;
  endfunction

  task automatic chk(input string tag, input logic ev, input logic [5:0] er, eg, eb);
    n_chk++;
    if ({valid, red, grn, blu} !== {ev, er, eg, eb}) begin
      n_bad++;
      $display("FAIL %s: act v=%b r=%h g=%h b=%h exp v=%b r=%h g=%h b=%h",
               tag, valid, red, grn, blu, ev, er, eg, eb);
    end
  endtask

  task automatic do_reset(input bit swp);
    rst_n = 1'b0;
    swap  = swp;
    lane  = '0;
    inv   = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset", 1'b0, 6'h0, 6'h0, 6'h0);
    rst_n = 1'b1;  // released just after a rising edge
  endtask

  // default order: half0 before rise, half1 before fall (R2 R4 R9)
  task automatic run_normal(input string tag);
    logic [18:0] pv;
    for (int p = 0; p < NVEC; p++) begin
      @(negedge clk); #1;
      inv  = VEC[p][18];
      lane = enc(VEC[p][17:12], VEC[p][11:6], VEC[p][5:0], 0, 1'b0, VEC[p][18], 3'(p * 5));
      @(posedge clk); #1;
      if (p == 0) chk("R6 first edge not valid", 1'b0, 6'h0, 6'h0, 6'h0);
      else begin
        pv = VEC[p-1];
        chk(tag, 1'b1, pv[17:12], pv[11:6], pv[5:0]);
      end
      lane = enc(VEC[p][17:12], VEC[p][11:6], VEC[p][5:0], 1, 1'b0, VEC[p][18], 3'(7 - p));
    end
    @(negedge clk); #1;
    @(posedge clk); #1;
    pv = VEC[NVEC-1];
    chk(tag, 1'b1, pv[17:12], pv[11:6], pv[5:0]);
  endtask

  // swapped: half0 before fall, half1 before rise (R3 R10)
  task automatic run_swapped(input string tag, input bit drop_strap);
    for (int p = 0; p < NVEC; p++) begin
      if (drop_strap && p == 2) swap = 1'b0;  // R8: no effect after reset
      inv  = VEC[p][18];
      lane = enc(VEC[p][17:12], VEC[p][11:6], VEC[p][5:0], 0, 1'b1, VEC[p][18], 3'(p * 3));
      @(negedge clk); #1;
      lane = enc(VEC[p][17:12], VEC[p][11:6], VEC[p][5:0], 1, 1'b1, VEC[p][18], 3'(~p));
      @(posedge clk); #1;
      chk(tag, 1'b1, VEC[p][17:12], VEC[p][11:6], VEC[p][5:0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    run_normal("R2 R4 R5 R7 R9 default map");
    do_reset(1'b1);
    run_swapped("R3 R5 R7 R10 swapped map", 1'b0);
    run_swapped("R8 strap change ignored", 1'b1);
    // R8: strap now low; a reset picks it up and default decoding returns
    do_reset(1'b0);
    run_normal("R8 default after re-reset");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule